// File: doc/BRIEF.md
# YCbCr 4:2:2 Lane Demultiplexer

This block takes 4:2:2 component video on two 8-bit input lanes and delivers one complete pixel (luma plus the co-sited Cb and Cr pair) per pixel period, with a one-cycle valid strobe. A single mode input selects the input format.

In narrow mode, one byte arrives per system clock on the low lane in the repeating order Cb, Y0, Cr, Y1, and the high lane is unused. In wide mode, the low lane carries luma and the high lane carries chroma, alternating Cb on even pixels and Cr on odd pixels. Both lanes are sampled once every two system clocks. The block divides the system clock by two to make the pixel clock it uses for wide-mode sampling, and it drives that clock out so a source can launch data on it. A line-start strobe marks the Cb sample, which realigns the byte or pixel phase. Interpolation to 4:4:4 and everything downstream are outside this block.

Top module: `ycc_lane_demux`

## Requirements
- R1: With `rst` high at a clock edge, `pix_valid` is low and `pix_y`, `pix_cb`, `pix_cr` and `pix_clk` are zero after that edge. The first input sampled after reset is taken as the Cb position without any `line_start`.
- R2: `pix_clk` toggles on every system clock edge after reset. It is high after the first edge following reset release.
- R3: In narrow mode (`wide_mode`=0), a byte sampled with `line_start`=1 is Cb, and the next three bytes are Y0, Cr and Y1. The pixel (Y0, Cb, Cr) appears with `pix_valid` after the edge that samples Y1.
- R4: In narrow mode, `lane_hi` has no effect on any output.
- R5: In wide mode, inputs are sampled only at edges where `pix_clk` was low before the edge, and values held at other edges are ignored. A sampled `line_start`=1 marks an even pixel, where `lane_hi` is Cb and `lane_lo` is Y. The following sample is odd, with `lane_hi` as Cr. Pixel (Y_even, Cb, Cr) is presented after the odd sample edge.
- R6: In both modes, the second pixel of a chroma pair (Y1, Cb, Cr) is presented exactly two edges after the first, which gives one pixel every two system clocks.
- R7: In wide mode, `line_start` asserted at an edge that is not a sampling edge has no effect.
- R8: `pix_valid` is never high for two consecutive cycles, and the pixel outputs change only in cycles where `pix_valid` is high.
- R9: A change of `wide_mode` drops any partly assembled or pending pixel. The next sample accepted in the new mode is taken as the Cb position.
- R10: A `line_start` that lands while the second pixel of the previous pair is pending does not disturb that pixel. The new pair follows at its normal offset from the `line_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (twice the pixel rate) |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 0: byte-interleaved low lane; 1: split luma/chroma lanes |
| line_start | input | 1 | Marks the Cb sample and realigns phase |
| lane_lo | input | 8 | Interleaved bytes (narrow) or luma (wide) |
| lane_hi | input | 8 | Alternating Cb/Cr (wide); unused in narrow |
| pix_clk | output | 1 | System clock divided by two |
| pix_valid | output | 1 | One-cycle strobe per output pixel |
| pix_y | output | 8 | Luma of the presented pixel |
| pix_cb | output | 8 | Cb of the presented pixel |
| pix_cr | output | 8 | Cr of the presented pixel |

## Verification
Two events can land on the same edge: a line-start realignment, and the delayed presentation of the second pixel of the previous chroma pair. A directed stream places `line_start` exactly on the edge where that held pixel is due. The bench then confirms that the old pixel still appears there with its original chroma, and that the new pair's first pixel appears three edges after the strobe. A second case switches mode on the edge after a Y1 capture, so the mode flush and the pending second pixel collide. That pixel must not appear.

// File: rtl/pdx_pkg.sv
package pdx_pkg;

    parameter int unsigned SAMPLE_W = 8;
    parameter int unsigned SECOND_PIX_DELAY = 2;
    localparam int unsigned WAIT_W = $clog2(SECOND_PIX_DELAY + 1);

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t y;
        sample_t cb;
        sample_t cr;
    } ycc_t;

    typedef enum logic [1:0] {
        SLOT_CB = 2'd0,
        SLOT_Y0 = 2'd1,
        SLOT_CR = 2'd2,
        SLOT_Y1 = 2'd3
    } slot_e;

    typedef struct packed {
        logic cb;
        logic y0;
        logic cr;
        logic y1;
    } cap_t;

    function automatic slot_e slot_after(input slot_e s);
        case (s)
            SLOT_CB: return SLOT_Y0;
            SLOT_Y0: return SLOT_CR;
            SLOT_CR: return SLOT_Y1;
            default: return SLOT_CB;
        endcase
    endfunction

endpackage

// File: rtl/pdx_clkgen.sv
module pdx_clkgen (
    input  logic clk,
    input  logic rst,
    output logic pix_clk,
    output logic smp_stb
);

    logic div_q;

    always_ff @(posedge clk) begin
        if (rst) div_q <= 1'b0;
        else     div_q <= ~div_q;
    end

    assign pix_clk = div_q;
    assign smp_stb = ~div_q;

    AST_PCLK_HALF: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (pix_clk != $past(pix_clk))); // R2

endmodule

// File: rtl/pdx_sorter.sv
module pdx_sorter
    import pdx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wide_mode,
    input  logic    line_start,
    input  logic    smp_stb,
    input  sample_t lane_lo,
    input  sample_t lane_hi,
    output cap_t    cap,
    output sample_t cap_y,
    output sample_t cap_c,
    output logic    mode_chg
);

    logic  mode_q;
    slot_e slot_q;
    slot_e slot_now;
    logic  odd_q;
    logic  even_now;

    assign mode_chg = wide_mode ^ mode_q;
    assign slot_now = line_start ? SLOT_CB : slot_q;
    assign even_now = line_start | ~odd_q;
    assign cap_y    = lane_lo;
    assign cap_c    = wide_mode ? lane_hi : lane_lo;

    always_comb begin
        cap = '0;
        if (!rst && !mode_chg) begin
            if (!wide_mode) begin
                case (slot_now)
                    SLOT_CB: cap.cb = 1'b1;
                    SLOT_Y0: cap.y0 = 1'b1;
                    SLOT_CR: cap.cr = 1'b1;
                    default: cap.y1 = 1'b1;
                endcase
            end else if (smp_stb) begin
                cap.cb = even_now;
                cap.y0 = even_now;
                cap.cr = ~even_now;
                cap.y1 = ~even_now;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || mode_chg) begin
            mode_q <= wide_mode;
            slot_q <= SLOT_CB;
            odd_q  <= 1'b0;
        end else if (!wide_mode) begin
            slot_q <= slot_after(slot_now);
        end else if (smp_stb) begin
            odd_q  <= even_now;
        end
    end

    AST_NARROW_ONE_SLOT: assert property (@(posedge clk) disable iff (rst)
        !wide_mode |-> $onehot0(cap)); // R3
    AST_NARROW_Y0_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!wide_mode && line_start && !mode_chg) ##1 (!wide_mode && !line_start && !mode_chg)
        |-> cap.y0); // R3
    AST_WIDE_SKIP_EDGE: assert property (@(posedge clk) disable iff (rst)
        (wide_mode && !mode_chg && cap.cb) |=> (cap == '0)); // R5

endmodule

// File: rtl/pdx_assembler.sv
module pdx_assembler
    import pdx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cap_t    cap,
    input  sample_t cap_y,
    input  sample_t cap_c,
    input  logic    mode_chg,
    output logic    out_valid,
    output ycc_t    out_pix
);

    sample_t           cb_q, y0_q, cr_q, y1_q;
    sample_t           snap_cb, snap_cr;
    sample_t           cr_now;
    logic [WAIT_W-1:0] wait_q;
    ycc_t              out_q;
    logic              vld_q;

    assign cr_now = cap.cr ? cap_c : cr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cb_q    <= '0;
            y0_q    <= '0;
            cr_q    <= '0;
            y1_q    <= '0;
            snap_cb <= '0;
            snap_cr <= '0;
            wait_q  <= '0;
            out_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            if (mode_chg) begin
                wait_q <= '0;
            end else begin
                if (cap.cb) cb_q <= cap_c;
                if (cap.y0) y0_q <= cap_y;
                if (cap.cr) cr_q <= cap_c;
                if (cap.y1) begin
                    out_q.y  <= y0_q;
                    out_q.cb <= cb_q;
                    out_q.cr <= cr_now;
                    vld_q    <= 1'b1;
                    y1_q     <= cap_y;
                    snap_cb  <= cb_q;
                    snap_cr  <= cr_now;
                    wait_q   <= WAIT_W'(SECOND_PIX_DELAY);
                end else if (wait_q == WAIT_W'(1)) begin
                    out_q.y  <= y1_q;
                    out_q.cb <= snap_cb;
                    out_q.cr <= snap_cr;
                    vld_q    <= 1'b1;
                    wait_q   <= '0;
                end else if (wait_q != '0) begin
                    wait_q   <= wait_q - WAIT_W'(1);
                end
            end
        end
    end

    assign out_valid = vld_q;
    assign out_pix   = out_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!out_valid && out_pix == '0)); // R1
    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R8
    AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_pix)); // R8
    AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (rst)
        mode_chg |=> !out_valid); // R9
    AST_NO_SLOT_CLASH: assert property (@(posedge clk) disable iff (rst)
        cap.y1 |-> (wait_q != WAIT_W'(1))); // R10

endmodule

// File: rtl/ycc_lane_demux.sv
module ycc_lane_demux
    import pdx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wide_mode,
    input  logic    line_start,
    input  sample_t lane_lo,
    input  sample_t lane_hi,
    output logic    pix_clk,
    output logic    pix_valid,
    output sample_t pix_y,
    output sample_t pix_cb,
    output sample_t pix_cr
);

    logic    smp_stb;
    cap_t    cap;
    sample_t cap_y;
    sample_t cap_c;
    logic    mode_chg;
    ycc_t    pix;

    pdx_clkgen u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .pix_clk (pix_clk),
        .smp_stb (smp_stb)
    );

    pdx_sorter u_sorter (
        .clk        (clk),
        .rst        (rst),
        .wide_mode  (wide_mode),
        .line_start (line_start),
        .smp_stb    (smp_stb),
        .lane_lo    (lane_lo),
        .lane_hi    (lane_hi),
        .cap        (cap),
        .cap_y      (cap_y),
        .cap_c      (cap_c),
        .mode_chg   (mode_chg)
    );

    pdx_assembler u_asm (
        .clk       (clk),
        .rst       (rst),
        .cap       (cap),
        .cap_y     (cap_y),
        .cap_c     (cap_c),
        .mode_chg  (mode_chg),
        .out_valid (pix_valid),
        .out_pix   (pix)
    );

    assign pix_y  = pix.y;
    assign pix_cb = pix.cb;
    assign pix_cr = pix.cr;

endmodule

// File: tb/sim_ycc_lane_demux.sv
module sim_ycc_lane_demux;

    localparam int WD_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wide_mode = 1'b0;
    logic       line_start = 1'b0;
    logic [7:0] lane_lo = '0;
    logic [7:0] lane_hi = '0;
    logic       pix_clk, pix_valid;
    logic [7:0] pix_y, pix_cb, pix_cr;

    ycc_lane_demux u0 (
        .clk(clk), .rst(rst), .wide_mode(wide_mode), .line_start(line_start),
        .lane_lo(lane_lo), .lane_hi(lane_hi), .pix_clk(pix_clk),
        .pix_valid(pix_valid), .pix_y(pix_y), .pix_cb(pix_cb), .pix_cr(pix_cr)
    );

    always #10 clk = ~clk;

    int ec = 0;
    always @(posedge clk) ec = ec + 1;

    int n_chk = 0;
    int n_fail = 0;
    int e0 = 0;
    bit done = 0;

    int         lg_n = 0;
    int         lg_t [64];
    logic [7:0] lg_y [64];
    logic [7:0] lg_cb[64];
    logic [7:0] lg_cr[64];
    int         hold_err = 0;
    logic [23:0] last = '0;

    always @(negedge clk) begin
        if (rst) begin
            last = '0;
        end else if (pix_valid) begin
            if (lg_n < 64) begin
                lg_t[lg_n]  = ec;
                lg_y[lg_n]  = pix_y;
                lg_cb[lg_n] = pix_cb;
                lg_cr[lg_n] = pix_cr;
            end
            lg_n = lg_n + 1;
            last = {pix_y, pix_cb, pix_cr};
        end else if ({pix_y, pix_cb, pix_cr} != last) begin
            hold_err = hold_err + 1;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic expect_px(input string rq, input int idx, input int t,
                             input int y, input int cb, input int cr);
        if (idx >= lg_n) begin
            chk({rq, " pixel count"}, lg_n, idx + 1);
        end else begin
            chk({rq, " stamp"}, lg_t[idx], t);
            chk({rq, " Y"},  lg_y[idx],  y);
            chk({rq, " Cb"}, lg_cb[idx], cb);
            chk({rq, " Cr"}, lg_cr[idx], cr);
        end
    endtask

    task automatic do_reset(input logic wide);
        @(negedge clk);
        rst = 1'b1; wide_mode = wide; line_start = 1'b0; lane_lo = '0; lane_hi = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        e0 = ec;
        lg_n = 0;
        hold_err = 0;
    endtask

    task automatic send_byte(input logic [7:0] lo, input logic [7:0] hi, input logic s);
        lane_lo = lo; lane_hi = hi; line_start = s;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic send_pair(input logic [7:0] y, input logic [7:0] c,
                             input logic s_on, input logic s_off);
        lane_lo = y; lane_hi = c; line_start = s_on;
        @(negedge clk);
        lane_lo = ~y; lane_hi = ~c; line_start = s_off;
        @(negedge clk);
        line_start = 1'b0;
    endtask

    task automatic idle(input int n);
        lane_lo = '0; lane_hi = '0; line_start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // R1, R2: reset state, divider, phase zero after reset
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; wide_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", pix_valid, 0);
        chk("R1 outputs in reset", {pix_y, pix_cb, pix_cr}, 0);
        chk("R1 pix_clk in reset", pix_clk, 0);
        rst = 1'b0; e0 = ec; lg_n = 0; hold_err = 0;
        send_byte(8'h11, 8'h00, 1'b0);
        chk("R2 pix_clk after first edge", pix_clk, 1);
        send_byte(8'h22, 8'h00, 1'b0);
        chk("R2 pix_clk second edge", pix_clk, 0);
        send_byte(8'h33, 8'h00, 1'b0);
        send_byte(8'h44, 8'h00, 1'b0);
        for (int k = 0; k < 6; k++) begin
            chk("R2 pix_clk phase", pix_clk, (ec - e0) & 1);
            idle(1);
        end
        expect_px("R1 phase zero px0", 0, e0 + 4, 8'h22, 8'h11, 8'h33);
        expect_px("R1 phase zero px1", 1, e0 + 6, 8'h44, 8'h11, 8'h33);
    endtask

    // R3, R4, R6, R8: narrow stream with junk on the high lane
    task automatic t_narrow();
        do_reset(1'b0);
        send_byte(8'h01, 8'hA5, 1'b1);
        send_byte(8'h02, 8'h5A, 1'b0);
        send_byte(8'h03, 8'hFF, 1'b0);
        send_byte(8'h04, 8'h3C, 1'b0);
        send_byte(8'h05, 8'hC3, 1'b0);
        send_byte(8'h06, 8'h99, 1'b0);
        send_byte(8'h07, 8'h66, 1'b0);
        send_byte(8'h08, 8'h0F, 1'b0);
        idle(8);
        expect_px("R3 narrow px0", 0, e0 + 4,  8'h02, 8'h01, 8'h03);
        expect_px("R6 narrow px1", 1, e0 + 6,  8'h04, 8'h01, 8'h03);
        expect_px("R4 hi lane ignored px2", 2, e0 + 8,  8'h06, 8'h05, 8'h07);
        expect_px("R4 hi lane ignored px3", 3, e0 + 10, 8'h08, 8'h05, 8'h07);
        chk("R8 outputs held between strobes", hold_err, 0);
    endtask

    // R5, R6, R7: wide mode, off-edge values inverted, off-edge line_start
    task automatic t_wide();
        do_reset(1'b1);
        send_pair(8'h10, 8'hC0, 1'b1, 1'b0);
        send_pair(8'h11, 8'hD0, 1'b0, 1'b1);
        send_pair(8'h12, 8'hC1, 1'b0, 1'b0);
        send_pair(8'h13, 8'hD1, 1'b0, 1'b1);
        idle(8);
        expect_px("R5 wide px0", 0, e0 + 3, 8'h10, 8'hC0, 8'hD0);
        expect_px("R6 wide px1", 1, e0 + 5, 8'h11, 8'hC0, 8'hD0);
        expect_px("R7 off-edge line_start px2", 2, e0 + 7, 8'h12, 8'hC1, 8'hD1);
        expect_px("R7 off-edge line_start px3", 3, e0 + 9, 8'h13, 8'hC1, 8'hD1);
        chk("R8 wide hold", hold_err, 0);
    endtask

    // R9: mode change right after a Y1 capture drops the pending pixel
    task automatic t_mode();
        do_reset(1'b0);
        send_byte(8'h31, 8'h00, 1'b1);
        send_byte(8'h32, 8'h00, 1'b0);
        send_byte(8'h33, 8'h00, 1'b0);
        send_byte(8'h34, 8'h00, 1'b0);
        wide_mode = 1'b1;
        send_byte(8'h00, 8'h00, 1'b0);
        chk("R9 pix_clk before wait", pix_clk, 1);
        idle(1);
        send_pair(8'h40, 8'hE4, 1'b0, 1'b0);
        send_pair(8'h41, 8'hF4, 1'b0, 1'b0);
        idle(4);
        expect_px("R9 before switch", 0, e0 + 4, 8'h32, 8'h31, 8'h33);
        expect_px("R9 after switch", 1, e0 + 9, 8'h40, 8'hE4, 8'hF4);
    endtask

    // R10: line_start on the edge where the held second pixel is due
    task automatic t_clash();
        do_reset(1'b0);
        send_byte(8'h51, 8'h00, 1'b1);
        send_byte(8'h52, 8'h00, 1'b0);
        send_byte(8'h53, 8'h00, 1'b0);
        send_byte(8'h54, 8'h00, 1'b0);
        send_byte(8'h00, 8'h00, 1'b0);
        send_byte(8'h61, 8'h00, 1'b1);
        send_byte(8'h62, 8'h00, 1'b0);
        send_byte(8'h63, 8'h00, 1'b0);
        send_byte(8'h64, 8'h00, 1'b0);
        idle(6);
        expect_px("R10 old px0", 0, e0 + 4,  8'h52, 8'h51, 8'h53);
        expect_px("R10 old px1 at line_start", 1, e0 + 6, 8'h54, 8'h51, 8'h53);
        expect_px("R10 new px0", 2, e0 + 9,  8'h62, 8'h61, 8'h63);
        expect_px("R10 new px1", 3, e0 + 11, 8'h64, 8'h61, 8'h63);
    endtask

    initial begin
        t_reset();
        t_narrow();
        t_wide();
        t_mode();
        t_clash();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(WD_CYCLES * 20);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule